// File: doc/BRIEF.md
# Cache Snoop Response Controller

This block holds the coherence state of a small direct-mapped cache in a shared-bus multiprocessor. It watches bus transactions from other agents and checks each snooped line address against a local tag, state and data array. Each line is in one of four states: modified, exclusive, shared or invalid. From that lookup it answers with a clean-hit flag or an active-low hit-modified flag, and it lowers the line's state as the transaction requires. When the snooped line is dirty, it drives the line's data back on the bus as an implicit write-back to the requester. There is no separate memory write in this case.

A memory-side model inside the block watches that same write-back and updates its backing copy. A later fill of the line therefore sees the supplied data. A local processor port reads and writes lines. A miss on this port fills the line from memory, and a dirty victim is written back to memory before the line is replaced. When a snoop lookup and a local access collide on the same set, the snoop wins.

Top module: `snoop_resp_ctrl`

## Requirements
- R1: After reset every line is invalid, `snp_rsp_valid_o`, `snp_hit_o`, `wb_valid_o`, `lcl_done_o` and `lcl_stall_o` are low, and `snp_hitm_no` is high.
- R2: A snoop sampled at clock edge t gives its response (`snp_rsp_valid_o` high together with the hit flags and write-back) only in the cycle between edges t+2 and t+3. Snoop op encoding on `snp_op_i`: 00 no snoop, 01 read, 10 read-for-ownership, 11 invalidate (write intent).
- R3: A snoop that misses the tag, or that matches a line already invalid, leaves the line unchanged and raises no hit, no hit-modified and no write-back.
- R4: An invalidate snoop to a shared line raises `snp_hit_o` and makes the line invalid. The next local read of that address misses and performs a fill (`lcl_fill_o` high).
- R5: Any snoop to a modified line drives `snp_hitm_no` low, keeps `snp_hit_o` low, and raises `wb_valid_o` with the line address on `wb_addr_o` and the dirty data on `wb_data_o`.
- R6: A read snoop to a modified line leaves it shared. A following local read hits and returns the same data without a fill.
- R7: A read-for-ownership or invalidate snoop to a modified line makes it invalid. The memory model captures the write-back, so the next local read misses and its fill returns the written-back data.
- R8: A snoop to an exclusive line raises `snp_hit_o` only (no hit-modified, no write-back). A read moves the line to shared. A read-for-ownership or invalidate moves it to invalid.
- R9: A local request to the same set (address bits [IDX_W-1:0]) as a snoop presented in the same cycle raises `lcl_stall_o` and is not accepted in that cycle. It is accepted on the first later edge without a conflict.
- R10: An accepted local access raises `lcl_done_o` for the one cycle after the accepting edge. A read hit returns the line data. A miss fills from memory. A read fill leaves the line exclusive. A write leaves the line modified with the write data and returns the write data.
- R11: A local miss whose victim line is modified writes the victim to memory first, so a later fill of the victim address returns its dirty data.
- R12: A local request to a set with an implicit write-back still in the response pipeline stalls until memory has captured it. With the default latency, a request presented right after the snoop edge stalls exactly three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snp_valid_i | input | 1 | Snoop transaction present on the bus |
| snp_op_i | input | 2 | Snoop op: 01 read, 10 read-for-ownership, 11 invalidate |
| snp_addr_i | input | ADDR_W | Snooped line address |
| snp_rsp_valid_o | output | 1 | Snoop response cycle |
| snp_hit_o | output | 1 | Snoop hit a clean (shared or exclusive) line |
| snp_hitm_no | output | 1 | Snoop hit a modified line, active low |
| wb_valid_o | output | 1 | Implicit write-back on the bus |
| wb_addr_o | output | ADDR_W | Write-back line address |
| wb_data_o | output | DATA_W | Write-back dirty data |
| lcl_req_i | input | 1 | Local access request |
| lcl_we_i | input | 1 | Local access is a write |
| lcl_addr_i | input | ADDR_W | Local line address |
| lcl_wdata_i | input | DATA_W | Local write data |
| lcl_stall_o | output | 1 | Local request not accepted this cycle |
| lcl_done_o | output | 1 | Local access completed |
| lcl_hit_o | output | 1 | Completed access hit the cache |
| lcl_fill_o | output | 1 | Completed access performed a line fill |
| lcl_rdata_o | output | DATA_W | Read data (write data on writes) |

## Verification
A wrong line state shows up in two places. The first is the response to the next snoop of that line, three edges after that snoop is sampled. The second is the hit and fill flags of the next local access, one edge after it is accepted. Each scenario therefore ends by reading back the line through a local access. That read exposes a state that stayed too high, as an unexpected hit, and one that dropped too far, as an extra fill. A lost memory update from the bus write-back appears as stale fill data on the first miss after the invalidating snoop. Stall counts show whether set conflicts and pending write-backs were ordered correctly.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'b00,
    LS_S = 2'b01,
    LS_E = 2'b10,
    LS_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    SOP_NONE = 2'b00,
    SOP_RD   = 2'b01,
    SOP_RFO  = 2'b10,
    SOP_INV  = 2'b11
  } snp_op_e;
endpackage

// File: rtl/snp_line_array.sv
module snp_line_array
  import snoop_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  sr_idx_i,
  output logic [TAG_W-1:0]  sr_tag_o,
  output line_st_e          sr_st_o,
  output logic [DATA_W-1:0] sr_data_o,
  input  logic [IDX_W-1:0]  lr_idx_i,
  output logic [TAG_W-1:0]  lr_tag_o,
  output line_st_e          lr_st_o,
  output logic [DATA_W-1:0] lr_data_o,
  input  logic              sw_en_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  line_st_e          sw_st_i,
  input  logic              lw_en_i,
  input  logic [IDX_W-1:0]  lw_idx_i,
  input  logic [TAG_W-1:0]  lw_tag_i,
  input  line_st_e          lw_st_i,
  input  logic [DATA_W-1:0] lw_data_i
);
  line_st_e          st_q   [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  assign sr_tag_o  = tag_q[sr_idx_i];
  assign sr_st_o   = st_q[sr_idx_i];
  assign sr_data_o = data_q[sr_idx_i];
  assign lr_tag_o  = tag_q[lr_idx_i];
  assign lr_st_o   = st_q[lr_idx_i];
  assign lr_data_o = data_q[lr_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SETS; i++) begin
        st_q[i]   <= LS_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SETS; i++) begin
        if (lw_en_i && lw_idx_i == IDX_W'(i)) begin
          st_q[i]   <= lw_st_i;
          tag_q[i]  <= lw_tag_i;
          data_q[i] <= lw_data_i;
        end else if (sw_en_i && sw_idx_i == IDX_W'(i)) begin
          st_q[i] <= sw_st_i;
        end
      end
    end
  end

  // R9
  port_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_i && lw_en_i) |-> (sw_idx_i != lw_idx_i));

  // R8
  snoop_no_upgrade_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_i |-> (sw_st_i != LS_M));
endmodule

// File: rtl/snp_decide.sv
module snp_decide
  import snoop_pkg::*;
(
  input  logic     valid_i,
  input  snp_op_e  op_i,
  input  logic     tag_eq_i,
  input  line_st_e st_i,
  output logic     hit_o,
  output logic     hitm_o,
  output logic     wb_o,
  output logic     upd_o,
  output line_st_e nxt_st_o
);
  logic present;
  assign present = valid_i && (op_i != SOP_NONE) && tag_eq_i && (st_i != LS_I);

  always_comb begin
    hit_o    = 1'b0;
    hitm_o   = 1'b0;
    wb_o     = 1'b0;
    nxt_st_o = st_i;
    if (present) begin
      nxt_st_o = (op_i == SOP_RD) ? LS_S : LS_I;
      if (st_i == LS_M) begin
        hitm_o = 1'b1;
        wb_o   = 1'b1;
      end else begin
        hit_o = 1'b1;
      end
    end
    upd_o = present && (nxt_st_o != st_i);
  end
endmodule

// File: rtl/snp_rsp_pipe.sv
module snp_rsp_pipe #(
  parameter int LAT    = 2,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              v_i,
  input  logic              hit_i,
  input  logic              hitm_i,
  input  logic              wb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  q_idx_i,
  output logic              pend_o,
  output logic              v_o,
  output logic              hit_o,
  output logic              hitm_o,
  output logic              wb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int NST = LAT + 1;

  logic [NST-1:0]    v_q, hit_q, hitm_q, wb_q;
  logic [ADDR_W-1:0] addr_q [NST];
  logic [DATA_W-1:0] data_q [NST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= '0;
      hit_q  <= '0;
      hitm_q <= '0;
      wb_q   <= '0;
      for (int k = 0; k < NST; k++) begin
        addr_q[k] <= '0;
        data_q[k] <= '0;
      end
    end else begin
      v_q[0]    <= v_i;
      hit_q[0]  <= hit_i;
      hitm_q[0] <= hitm_i;
      wb_q[0]   <= wb_i;
      addr_q[0] <= addr_i;
      data_q[0] <= data_i;
      for (int k = 1; k < NST; k++) begin
        v_q[k]    <= v_q[k-1];
        hit_q[k]  <= hit_q[k-1];
        hitm_q[k] <= hitm_q[k-1];
        wb_q[k]   <= wb_q[k-1];
        addr_q[k] <= addr_q[k-1];
        data_q[k] <= data_q[k-1];
      end
    end
  end

  // write-back stays pending until memory captures it after the last stage
  always_comb begin
    pend_o = 1'b0;
    for (int k = 0; k < NST; k++)
      if (wb_q[k] && addr_q[k][IDX_W-1:0] == q_idx_i) pend_o = 1'b1;
  end

  assign v_o    = v_q[LAT];
  assign hit_o  = hit_q[LAT];
  assign hitm_o = hitm_q[LAT];
  assign wb_o   = wb_q[LAT];
  assign addr_o = addr_q[LAT];
  assign data_o = data_q[LAT];

  // R5
  wb_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> (v_o && hitm_o));
endmodule

// File: rtl/mem_side_model.sv
module mem_side_model #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wb_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              vic_wr_i,
  input  logic [ADDR_W-1:0] vic_addr_i,
  input  logic [DATA_W-1:0] vic_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (bus_wb_i) mem_q[bus_addr_i] <= bus_data_i;
      if (vic_wr_i) mem_q[vic_addr_i] <= vic_data_i;
    end
  end

  // R12
  wr_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wb_i && vic_wr_i) |-> (bus_addr_i != vic_addr_i));
endmodule

// File: rtl/snoop_resp_ctrl.sv
module snoop_resp_ctrl
  import snoop_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int SETS    = 8,
  parameter int RSP_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_rsp_valid_o,
  output logic              snp_hit_o,
  output logic              snp_hitm_no,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  input  logic              lcl_req_i,
  input  logic              lcl_we_i,
  input  logic [ADDR_W-1:0] lcl_addr_i,
  input  logic [DATA_W-1:0] lcl_wdata_i,
  output logic              lcl_stall_o,
  output logic              lcl_done_o,
  output logic              lcl_hit_o,
  output logic              lcl_fill_o,
  output logic [DATA_W-1:0] lcl_rdata_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] s_idx, l_idx;
  logic [TAG_W-1:0] s_tag, l_tag;
  assign s_idx = snp_addr_i[IDX_W-1:0];
  assign s_tag = snp_addr_i[ADDR_W-1:IDX_W];
  assign l_idx = lcl_addr_i[IDX_W-1:0];
  assign l_tag = lcl_addr_i[ADDR_W-1:IDX_W];

  logic [TAG_W-1:0]  sr_tag, lr_tag;
  line_st_e          sr_st, lr_st, sw_st, lw_st;
  logic [DATA_W-1:0] sr_data, lr_data, lw_data, mem_rd;
  logic              sw_en, lw_en;

  logic d_hit, d_hitm, d_wb;
  logic p_pend, p_v, p_hit, p_hitm, p_wb;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_data;

  snp_line_array #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_arr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sr_idx_i (s_idx),
    .sr_tag_o (sr_tag),
    .sr_st_o  (sr_st),
    .sr_data_o(sr_data),
    .lr_idx_i (l_idx),
    .lr_tag_o (lr_tag),
    .lr_st_o  (lr_st),
    .lr_data_o(lr_data),
    .sw_en_i  (sw_en),
    .sw_idx_i (s_idx),
    .sw_st_i  (sw_st),
    .lw_en_i  (lw_en),
    .lw_idx_i (l_idx),
    .lw_tag_i (l_tag),
    .lw_st_i  (lw_st),
    .lw_data_i(lw_data)
  );

  snp_decide u_dec (
    .valid_i (snp_valid_i),
    .op_i    (snp_op_e'(snp_op_i)),
    .tag_eq_i(sr_tag == s_tag),
    .st_i    (sr_st),
    .hit_o   (d_hit),
    .hitm_o  (d_hitm),
    .wb_o    (d_wb),
    .upd_o   (sw_en),
    .nxt_st_o(sw_st)
  );

  snp_rsp_pipe #(
    .LAT(RSP_LAT), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (snp_valid_i && (snp_op_i != SOP_NONE)),
    .hit_i  (d_hit),
    .hitm_i (d_hitm),
    .wb_i   (d_wb),
    .addr_i (snp_addr_i),
    .data_i (sr_data),
    .q_idx_i(l_idx),
    .pend_o (p_pend),
    .v_o    (p_v),
    .hit_o  (p_hit),
    .hitm_o (p_hitm),
    .wb_o   (p_wb),
    .addr_o (p_addr),
    .data_o (p_data)
  );

  assign snp_rsp_valid_o = p_v;
  assign snp_hit_o       = p_hit;
  assign snp_hitm_no     = ~p_hitm;
  assign wb_valid_o      = p_wb;
  assign wb_addr_o       = p_addr;
  assign wb_data_o       = p_data;

  // local side: snoops own the set this cycle; pending write-backs block fills
  logic fire, l_hit, vic_wr;
  logic [ADDR_W-1:0] vic_addr;

  assign lcl_stall_o = lcl_req_i && ((snp_valid_i && s_idx == l_idx) || p_pend);
  assign fire        = lcl_req_i && !lcl_stall_o;
  assign l_hit       = (lr_st != LS_I) && (lr_tag == l_tag);
  assign vic_wr      = fire && !l_hit && (lr_st == LS_M);
  assign vic_addr    = {lr_tag, l_idx};

  assign lw_en   = fire && (lcl_we_i || !l_hit);
  assign lw_st   = lcl_we_i ? LS_M : LS_E;
  assign lw_data = lcl_we_i ? lcl_wdata_i : mem_rd;

  mem_side_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_wb_i  (p_wb),
    .bus_addr_i(p_addr),
    .bus_data_i(p_data),
    .vic_wr_i  (vic_wr),
    .vic_addr_i(vic_addr),
    .vic_data_i(lr_data),
    .rd_addr_i (lcl_addr_i),
    .rd_data_o (mem_rd)
  );

  logic              done_q, hit_q, fill_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      fill_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= fire;
      hit_q  <= fire && l_hit;
      fill_q <= fire && !l_hit;
      if (fire) rdata_q <= lcl_we_i ? lcl_wdata_i : (l_hit ? lr_data : mem_rd);
    end
  end

  assign lcl_done_o  = done_q;
  assign lcl_hit_o   = hit_q;
  assign lcl_fill_o  = fill_q;
  assign lcl_rdata_o = rdata_q;

  // R5
  hitm_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_hitm_no |-> (wb_valid_o && snp_rsp_valid_o));

  // R8
  hit_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snp_hit_o && !snp_hitm_no));

  // R9
  set_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcl_req_i && snp_valid_i && s_idx == l_idx) |=> !lcl_done_o);

  // R10
  fill_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcl_fill_o |-> (lcl_done_o && !lcl_hit_o));
endmodule

// File: tb/sim_snoop_resp_ctrl.sv
module sim_snoop_resp_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_op = 2'b00;
  logic [7:0]  snp_addr = '0;
  logic        rsp_valid, s_hit, s_hitm_n, wb_valid;
  logic [7:0]  wb_addr;
  logic [31:0] wb_data;
  logic        lcl_req = 1'b0, lcl_we = 1'b0;
  logic [7:0]  lcl_addr = '0;
  logic [31:0] lcl_wdata = '0;
  logic        stall, done, l_hit, l_fill;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_resp_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_addr_i(snp_addr),
    .snp_rsp_valid_o(rsp_valid), .snp_hit_o(s_hit), .snp_hitm_no(s_hitm_n),
    .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .wb_data_o(wb_data),
    .lcl_req_i(lcl_req), .lcl_we_i(lcl_we), .lcl_addr_i(lcl_addr),
    .lcl_wdata_i(lcl_wdata), .lcl_stall_o(stall), .lcl_done_o(done),
    .lcl_hit_o(l_hit), .lcl_fill_o(l_fill), .lcl_rdata_o(rdata)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // snoop: drive at a negedge, response checked after edge t+2
  task automatic snoop_chk(input string rq, input logic [1:0] op, input logic [7:0] a,
                           input logic e_hit, input logic e_hitm_n, input logic e_wb,
                           input logic [31:0] e_data);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0; snp_op = 2'b00;
    chk("R2", "rsp early t", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    chk("R2", "rsp early t+1", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    chk("R2", "rsp valid t+2", {31'd0, rsp_valid}, 32'd1);
    chk(rq, "snp_hit", {31'd0, s_hit}, {31'd0, e_hit});
    chk(rq, "snp_hitm_n", {31'd0, s_hitm_n}, {31'd0, e_hitm_n});
    chk(rq, "wb_valid", {31'd0, wb_valid}, {31'd0, e_wb});
    if (e_wb) begin
      chk(rq, "wb_addr", {24'd0, wb_addr}, {24'd0, a});
      chk(rq, "wb_data", wb_data, e_data);
    end
  endtask

  // local access; returns after done cycle is visible
  task automatic lcl_do(input logic we, input logic [7:0] a, input logic [31:0] d,
                        output logic h, output logic f, output logic [31:0] rd,
                        output int stalls);
    logic st;
    lcl_req = 1'b1; lcl_we = we; lcl_addr = a; lcl_wdata = d;
    stalls = 0;
    for (int n = 0; n < 40; n++) begin
      #1 st = stall;
      @(negedge clk);
      if (!st) break;
      stalls++;
    end
    lcl_req = 1'b0; lcl_we = 1'b0;
    chk("R10", "lcl_done", {31'd0, done}, 32'd1);
    h = l_hit; f = l_fill; rd = rdata;
  endtask

  task automatic lcl_chk(input string rq, input logic we, input logic [7:0] a,
                         input logic [31:0] d, input logic e_hit, input logic [31:0] e_rd);
    logic h, f;
    logic [31:0] rd;
    int s;
    lcl_do(we, a, d, h, f, rd, s);
    chk(rq, "lcl_hit", {31'd0, h}, {31'd0, e_hit});
    chk(rq, "lcl_fill", {31'd0, f}, {31'd0, ~e_hit});
    chk(rq, "lcl_rdata", rd, e_rd);
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1", "snp_hit", {31'd0, s_hit}, 32'd0);
    chk("R1", "hitm_n", {31'd0, s_hitm_n}, 32'd1);
    chk("R1", "wb_valid", {31'd0, wb_valid}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "stall", {31'd0, stall}, 32'd0);
    snoop_chk("R3", 2'b01, 8'h10, 1'b0, 1'b1, 1'b0, 32'd0);
  endtask

  task automatic t_excl_read;
    lcl_chk("R10", 1'b0, 8'h11, 32'd0, 1'b0, 32'd0);
    lcl_chk("R10", 1'b0, 8'h11, 32'd0, 1'b1, 32'd0);
    snoop_chk("R8", 2'b01, 8'h11, 1'b1, 1'b1, 1'b0, 32'd0);
    lcl_chk("R8", 1'b0, 8'h11, 32'd0, 1'b1, 32'd0);
  endtask

  task automatic t_shared_inv;
    snoop_chk("R4", 2'b11, 8'h11, 1'b1, 1'b1, 1'b0, 32'd0);
    snoop_chk("R3", 2'b01, 8'h11, 1'b0, 1'b1, 1'b0, 32'd0);
    lcl_chk("R4", 1'b0, 8'h11, 32'd0, 1'b0, 32'd0);
  endtask

  task automatic t_mod_read;
    lcl_chk("R10", 1'b1, 8'h22, 32'hA5A5_0001, 1'b0, 32'hA5A5_0001);
    lcl_chk("R10", 1'b1, 8'h22, 32'hA5A5_0002, 1'b1, 32'hA5A5_0002);
    snoop_chk("R5", 2'b01, 8'h22, 1'b0, 1'b0, 1'b1, 32'hA5A5_0002);
    lcl_chk("R6", 1'b0, 8'h22, 32'd0, 1'b1, 32'hA5A5_0002);
  endtask

  task automatic t_mod_rfo;
    lcl_chk("R10", 1'b1, 8'h23, 32'h0000_1234, 1'b0, 32'h0000_1234);
    snoop_chk("R5", 2'b10, 8'h23, 1'b0, 1'b0, 1'b1, 32'h0000_1234);
    lcl_chk("R7", 1'b0, 8'h23, 32'd0, 1'b0, 32'h0000_1234);
  endtask

  task automatic t_excl_rfo;
    lcl_chk("R10", 1'b0, 8'h14, 32'd0, 1'b0, 32'd0);
    snoop_chk("R8", 2'b10, 8'h14, 1'b1, 1'b1, 1'b0, 32'd0);
    lcl_chk("R8", 1'b0, 8'h14, 32'd0, 1'b0, 32'd0);
  endtask

  task automatic t_set_conflict;
    snp_valid = 1'b1; snp_op = 2'b01; snp_addr = 8'h0d;
    lcl_req = 1'b1; lcl_we = 1'b0; lcl_addr = 8'h05;
    #1 chk("R9", "stall on same set", {31'd0, stall}, 32'd1);
    @(negedge clk);
    chk("R9", "not accepted", {31'd0, done}, 32'd0);
    snp_valid = 1'b0; snp_op = 2'b00;
    #1 chk("R9", "stall released", {31'd0, stall}, 32'd0);
    @(negedge clk);
    lcl_req = 1'b0;
    chk("R9", "accepted next", {31'd0, done}, 32'd1);
    chk("R9", "fill", {31'd0, l_fill}, 32'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_evict;
    lcl_chk("R10", 1'b1, 8'h06, 32'h0000_CAFE, 1'b0, 32'h0000_CAFE);
    lcl_chk("R11", 1'b0, 8'h0e, 32'd0, 1'b0, 32'd0);
    lcl_chk("R11", 1'b0, 8'h06, 32'd0, 1'b0, 32'h0000_CAFE);
  endtask

  task automatic t_pending_wb;
    logic h, f;
    logic [31:0] rd;
    int s;
    lcl_chk("R10", 1'b1, 8'h07, 32'h0000_0077, 1'b0, 32'h0000_0077);
    snp_valid = 1'b1; snp_op = 2'b11; snp_addr = 8'h07;
    @(negedge clk);
    snp_valid = 1'b0; snp_op = 2'b00;
    lcl_do(1'b0, 8'h07, 32'd0, h, f, rd, s);
    chk("R12", "stall cycles", s, 32'd3);
    chk("R12", "fill", {31'd0, f}, 32'd1);
    chk("R12", "fill data", rd, 32'h0000_0077);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_excl_read();
    t_shared_inv();
    t_mod_read();
    t_mod_rfo();
    t_excl_rfo();
    t_set_conflict();
    t_evict();
    t_pending_wb();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule